// File: doc/BRIEF.md
# Converter Power-Down Sequencer

This block drives the two power-down control lines of a parallel-output sampling converter from a host's mode request. The host asks for one of three states: running, a light power-down that wakes quickly, or a deep power-down that wakes slowly. One select line picks which power-down state the converter enters. An active-low line then puts the converter into that state. The sequencer first settles the select line and only then pulls the power-down line low. On leaving power-down, it raises the line and keeps its ready flag low until the wake-up time for the state just left has run out. The conversion controller must not start a conversion while ready is low.

The setup time and both wake-up times are given in nanoseconds as parameters and converted to clock cycles, rounded up. The deep wake-up time defaults to 10 ms. After reset the power-down line is high, but ready stays low for one full deep wake-up time, because the converter's state is unknown at that point. A new power-down request that arrives while the converter is already down first wakes the converter, waiting out the full wake-up time. The sequencer then sets the select line again and goes back down, without raising ready in between.

Top module: `adc_pwr_seq`

## Requirements
- R1: During reset, `pd_n_o` is 1, `ready_o` is 0 and `nap_sel_o` is 0 (deep power-down selected).
- R2: After reset is released, `ready_o` stays 0 for exactly DEEP_CYC cycles, then goes to 1. DEEP_CYC = ceil(DEEP_WAKE_NS / CLK_NS).
- R3: `req_i` uses the codes 2'b00 = run, 2'b01 = light power-down, 2'b10 = deep power-down and 2'b11 = run. A light request while running sets `nap_sel_o` to 1 and drops `ready_o` in the next cycle. `pd_n_o` stays 1 for exactly SETUP_CYC cycles and then falls. SETUP_CYC = ceil(SETUP_NS / CLK_NS), with a minimum of 1.
- R4: A deep request while running sets `nap_sel_o` to 0 and keeps `pd_n_o` at 1 for exactly SETUP_CYC cycles before it falls.
- R5: While `pd_n_o` is 0, `nap_sel_o` does not change. When `pd_n_o` falls, `nap_sel_o` has held its value for at least SETUP_CYC cycles.
- R6: Leaving light power-down: `pd_n_o` rises in the cycle after the run request. `ready_o` stays 0 for exactly NAP_CYC cycles, counted from that cycle. NAP_CYC = ceil(NAP_WAKE_NS / CLK_NS).
- R7: Leaving deep power-down works the same way, but `ready_o` stays 0 for exactly DEEP_CYC cycles.
- R8: If the request changes to the other power-down state while the converter is down, `pd_n_o` stays 1 for the old state's wake-up time plus SETUP_CYC cycles. `nap_sel_o` keeps its old value during the wake-up, then changes. `ready_o` stays 0 throughout, and then `pd_n_o` falls again.
- R9: Holding the current power-down request keeps `pd_n_o` at 0 and `ready_o` at 0. `ready_o` is 1 only while `pd_n_o` is 1.
- R10: Request code 2'b11 behaves as run: it wakes the converter with the same timing as 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 2 | Requested state: 00 run, 01 light power-down, 10 deep power-down, 11 run |
| nap_sel_o | output | 1 | Power-down state select: 1 light, 0 deep |
| pd_n_o | output | 1 | Active-low power-down command to the converter |
| ready_o | output | 1 | High when a conversion start is allowed |

## Verification
The assertions check every cycle that ready is never high while the converter is powered down. They check that the select line is frozen while the power-down line is low and has been stable for the setup time when the line falls. They also check that ready never rises before the wake-up time of the mode just left has elapsed, as measured by separate counters. These checks only set lower bounds. The bench scenarios show that each window has exactly the expected length. They also show that the requests are decoded correctly, that code 2'b11 wakes like run, and that a mode change while down passes through a full wake-up without a ready pulse.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  typedef enum logic [1:0] {
    ST_WAKE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SETUP = 2'd2,
    ST_DOWN  = 2'd3
  } seq_state_e;

  // Duration in ns to whole clock cycles, rounded up, at least one cycle.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned r;
    r = (ns + per - 1) / per;
    if (r == 0) r = 1;
    return r;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Request decode: 01 light, 10 deep, 00/11 run.
  function automatic logic is_pd_req(input logic [1:0] r);
    return (r == 2'b01) || (r == 2'b10);
  endfunction

  function automatic logic req_is_nap(input logic [1:0] r);
    return r == 2'b01;
  endfunction

  // Code of the power-down request matching a given select value.
  function automatic logic [1:0] sel_to_req(input logic nap);
    return nap ? 2'b01 : 2'b10;
  endfunction

endpackage

// File: rtl/pwr_wait_timer.sv
module pwr_wait_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= W'(RST_VAL);
    else if (load_i)     cnt_q <= load_val_i;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // Once expired, the timer stays expired until reloaded (R6, R7 windows).
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !load_i |=> done_o);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import adc_pwr_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned NAP_CYC   = 20,
  parameter int unsigned DEEP_CYC  = 300
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   req_i,
  input  logic         tmr_done_i,
  output logic         tmr_load_o,
  output logic [W-1:0] tmr_val_o,
  output seq_state_e   state_o,
  output logic         nap_sel_o
);
  localparam logic [W-1:0] SETUP_LD = W'(SETUP_CYC - 1);
  localparam logic [W-1:0] NAP_LD   = W'(NAP_CYC - 1);
  localparam logic [W-1:0] DEEP_LD  = W'(DEEP_CYC - 1);

  seq_state_e state_q, state_d;
  logic       nap_q, nap_d;

  always_comb begin
    state_d    = state_q;
    nap_d      = nap_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = SETUP_LD;
    unique case (state_q)
      ST_RUN: if (is_pd_req(req_i)) begin
        state_d    = ST_SETUP;
        nap_d      = req_is_nap(req_i);
        tmr_load_o = 1'b1;
      end
      ST_SETUP: if (tmr_done_i) state_d = ST_DOWN;
      ST_DOWN: if (req_i != sel_to_req(nap_q)) begin
        state_d    = ST_WAKE;
        tmr_load_o = 1'b1;
        tmr_val_o  = nap_q ? NAP_LD : DEEP_LD;
      end
      ST_WAKE: if (tmr_done_i) begin
        if (is_pd_req(req_i)) begin
          state_d    = ST_SETUP;
          nap_d      = req_is_nap(req_i);
          tmr_load_o = 1'b1;
        end else begin
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_WAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAKE;
      nap_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      nap_q   <= nap_d;
    end
  end

  assign state_o   = state_q;
  assign nap_sel_o = nap_q;

  // R5: select changes only when entering the setup phase.
  a_r5_sel_change_only_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (nap_q != $past(nap_q)) |-> (state_q == ST_SETUP));
  // R6/R7: power-down is always left through the wake-up phase.
  a_r6_down_exits_to_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DOWN) |=> (state_q == ST_DOWN || state_q == ST_WAKE));
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int unsigned CLK_NS       = 10,
  parameter int unsigned SETUP_NS     = 10,
  parameter int unsigned NAP_WAKE_NS  = 200,
  parameter int unsigned DEEP_WAKE_NS = 10_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_i,
  output logic       nap_sel_o,
  output logic       pd_n_o,
  output logic       ready_o
);
  localparam int unsigned SETUP_CYC = ns_to_cyc(SETUP_NS, CLK_NS);
  localparam int unsigned NAP_CYC   = ns_to_cyc(NAP_WAKE_NS, CLK_NS);
  localparam int unsigned DEEP_CYC  = ns_to_cyc(DEEP_WAKE_NS, CLK_NS);
  localparam int unsigned MAX_CYC   = max3(SETUP_CYC, NAP_CYC, DEEP_CYC);
  localparam int unsigned W         = $clog2(MAX_CYC + 1);

  logic         tmr_load, tmr_done;
  logic [W-1:0] tmr_val;
  seq_state_e   state;

  pwr_wait_timer #(.W(W), .RST_VAL(DEEP_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val), .done_o(tmr_done)
  );

  pwr_seq_ctrl #(.W(W), .SETUP_CYC(SETUP_CYC), .NAP_CYC(NAP_CYC), .DEEP_CYC(DEEP_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .tmr_done_i(tmr_done),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .state_o(state), .nap_sel_o(nap_sel_o)
  );

  assign pd_n_o  = (state != ST_DOWN);
  assign ready_o = (state == ST_RUN);

  // Independent window counters, used only by the assertions below.
  logic         sel_q;
  logic [W:0]   sel_stable_cnt;
  logic [W:0]   awake_cnt;
  wire          sel_changed = (nap_sel_o != sel_q);
  wire [W:0]    wake_need   = nap_sel_o ? (W+1)'(NAP_CYC) : (W+1)'(DEEP_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q          <= 1'b0;
      sel_stable_cnt <= '0;
      awake_cnt      <= '0;
    end else begin
      sel_q <= nap_sel_o;
      if (sel_changed)                        sel_stable_cnt <= 1;
      else if (sel_stable_cnt != {(W+1){1'b1}}) sel_stable_cnt <= sel_stable_cnt + 1'b1;
      if (!pd_n_o)                            awake_cnt <= '0;
      else if (awake_cnt != {(W+1){1'b1}})    awake_cnt <= awake_cnt + 1'b1;
    end
  end

  a_r9_ready_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> pd_n_o);
  a_r5_sel_frozen_while_down: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n_o && !$rose(rst_n) |-> $stable(nap_sel_o));
  a_r3_setup_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_n_o) |-> (sel_stable_cnt >= (W+1)'(SETUP_CYC)));
  a_r7_wake_window_met: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (awake_cnt >= wake_need));
  a_r6_not_ready_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_n_o) |-> !ready_o);
endmodule

// File: tb/adc_pwr_seq_tb_top.sv
module adc_pwr_seq_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned T_SETUP    = 25;
  localparam int unsigned T_NAP      = 200;
  localparam int unsigned T_DEEP     = 3000;
  localparam int unsigned WDOG       = 150000;

  // Expected windows, restated from the requirements (ceil, min 1).
  localparam int S_EXP = (T_SETUP + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int N_EXP = (T_NAP + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int D_EXP = (T_DEEP + CLK_PERIOD - 1) / CLK_PERIOD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] req = 2'b00;
  logic nap_sel, pd_n, ready;
  int checks = 0, fails = 0, cyc = 0;

  adc_pwr_seq #(.CLK_NS(CLK_PERIOD), .SETUP_NS(T_SETUP), .NAP_WAKE_NS(T_NAP),
                .DEEP_WAKE_NS(T_DEEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .nap_sel_o(nap_sel), .pd_n_o(pd_n), .ready_o(ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < %0d", cyc, WDOG);
      summary();
      $finish;
    end
  end

  task automatic check(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  // Counts cycles with pd_n high while asking for mode 'code'; checks select and ready.
  task automatic go_down(input logic [1:0] code, input string tag);
    int n = 0, bad = 0;
    req = code;
    @(negedge clk);
    while (pd_n && n < 2000) begin
      if (ready || nap_sel != (code == 2'b01)) bad++;
      n++;
      @(negedge clk);
    end
    check({tag, " setup window length"}, n, S_EXP);
    check({tag, " select/ready during setup"}, bad, 0);
    check({tag, " select while down"}, int'(nap_sel), int'(code == 2'b01));
  endtask

  // Counts cycles with ready low after requesting 'code' from the down state.
  task automatic wake(input logic [1:0] code, input int exp, input string tag);
    int n = 0;
    req = code;
    @(negedge clk);
    check({tag, " power-down released"}, int'(pd_n), 1);
    while (!ready && n < 20000) begin
      n++;
      @(negedge clk);
    end
    check({tag, " wake window length"}, n, exp);
  endtask

  task automatic t_reset();
    int n = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 pd_n in reset", int'(pd_n), 1);
    check("R1 ready in reset", int'(ready), 0);
    check("R1 select in reset", int'(nap_sel), 0);
    rst_n = 1'b1;
    while (!ready && n < 20000) begin
      n++;
      @(negedge clk);
    end
    check("R2 ready delay after reset", n, D_EXP);
  endtask

  task automatic t_nap_cycle();
    int bad = 0;
    go_down(2'b01, "R3");
    for (int i = 0; i < 40; i++) begin
      if (pd_n || ready || !nap_sel) bad++;
      @(negedge clk);
    end
    check("R9/R5 hold light request stays down", bad, 0);
    wake(2'b00, N_EXP, "R6");
  endtask

  task automatic t_deep_cycle();
    go_down(2'b10, "R4");
    repeat (10) @(negedge clk);
    check("R9 deep held down", int'(pd_n), 0);
    wake(2'b00, D_EXP, "R7");
  endtask

  task automatic t_alt_run_code();
    go_down(2'b01, "R10 prep");
    wake(2'b11, N_EXP, "R10");
  endtask

  task automatic t_switch_down();
    int n = 0, rdy = 0, early_sel = 0;
    go_down(2'b01, "R8 prep");
    req = 2'b10;
    @(negedge clk);
    while (pd_n && n < 20000) begin
      if (ready) rdy++;
      if (n < N_EXP && !nap_sel) early_sel++;
      n++;
      @(negedge clk);
    end
    check("R8 high window = light wake + setup", n, N_EXP + S_EXP);
    check("R8 no ready pulse", rdy, 0);
    check("R8 old select held during wake", early_sel, 0);
    check("R8 new select deep", int'(nap_sel), 0);
    wake(2'b00, D_EXP, "R8/R7 deep");
  endtask

  initial begin
    t_reset();
    t_nap_cycle();
    t_deep_cycle();
    t_alt_run_code();
    t_switch_down();
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule